// File: doc/BRIEF.md
# Wired Interrupt Gateway with Message-Signaled Delivery

This block collects a parameterizable number of wired interrupt sources for one interrupt domain and turns them into message-signaled interrupts (MSIs). Sources carry identity numbers 1 to N. Each one has a 3-bit trigger mode that selects how its wire is read: ignored, edge-sensitive (either polarity) or level-sensitive (either polarity). A detached mode keeps the source active while it ignores the wire, so only software can make it pending. Each source has a pending bit and an enable bit.

Software programs the block through a single-cycle write port. One write kind sets the domain's global enable, its delivery mode, and the two fields used to extract a group index from a target page number. Further kinds set each source's trigger mode and target hart, enable or disable one source, or make one source pending, each by naming the source's identity number. The last kind loads each hart's MSI page number.

A source that is active, enabled and pending can be delivered, provided the domain is enabled and set to MSI delivery. The lowest such identity is captured into a single outstanding message. That message is presented on a valid/ready handshake and carries the hart's page address, the identity as data and the extracted group index.

Top module: `irq_msi_gateway`

## Requirements
- R1: After reset no message is valid, every source is disabled and in mode 0, and the domain is disabled; toggling source wires then produces no message.
- R2: Kinds 2 (enable), 3 (disable) and 4 (set pending) take an identity in wrData[9:0]. Identity 0 and identities above N are ignored. Kind 1 (mode) addresses identity i through wrIndex = i-1, with the mode in wrData[2:0] and the target hart in wrData[8 +: hart-index width].
- R3: Mode values 2 and 3 behave exactly like mode 0: the source is inactive, it never becomes pending, and its pending bit is cleared.
- R4: In mode 4 the pending bit is set on a rising wire edge, and in mode 5 on a falling edge. A wire held steady gives no further message. The pending bit clears when that source's message handshake completes.
- R5: In mode 6 (high) and mode 7 (low) the pending bit follows the asserted level while the source is enabled, so messages repeat while the level stays asserted. Deasserting or disabling the source stops them.
- R6: In mode 1 the wire has no effect, and only a set-pending write makes the source pending.
- R7: A message is started only when domain bit 0 (global enable, kind 0) and bit 1 (MSI delivery) are both 1. A pending edge or detached source keeps its pending bit while delivery is blocked.
- R8: Of the deliverable sources, the lowest identity is sent first. At most one message is outstanding. msiValid and its payload hold until msiReady is seen, and msiValid is low in the cycle after a handshake.
- R9: msiAddr is the target hart's page number (kind 5, wrIndex = hart) shifted left by 12. msiData is the identity. msiGroup is the page number shifted right by (group shift + 12), masked to the group width, where the shift is domain bits [6:2] and the width is domain bits [9:7].
- R10: A pending edge source that is switched to mode 0 and back loses its pending state and sends nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 3 | Write kind: 0 domain, 1 mode, 2 enable, 3 disable, 4 set pending, 5 hart page |
| wrIndex | input | 10 | Source index (identity-1) for kind 1, hart number for kind 5 |
| wrData | input | DATA_W | Write data |
| srcIn | input | NUM_SRC | Source wires, bit k is identity k+1 |
| msiReady | input | 1 | Message accepted by the fabric |
| msiValid | output | 1 | Message outstanding |
| msiAddr | output | DATA_W+12 | Target page address |
| msiData | output | 10 | Source identity carried by the message |
| msiGroup | output | 7 | Group index extracted from the target page |

## Verification
The bench aims at identity 0 writes. A design that took identity 0 as valid would wrap it to the last source or to source 1, and enable a source that should stay silent. Reserved modes and mode round-trips are exercised, and a block that kept a stale pending bit would send a message after the source came back. Long high and low levels check that the level modes re-arm, and that a wrongly edge-converted level would fire only once. Random sets of sources are made pending while delivery is blocked and then released against a randomly stalling ready. A wrong priority scan would break the ascending order, a payload that changed under stall would fail the hold check, and an off-by-12 in the group shift would give a wrong msiGroup.

// File: rtl/irq_msi_gateway_pkg.sv
package irq_msi_gateway_pkg;

  localparam int ID_W      = 10;  // identities up to 1023
  localparam int SHIFT_W   = 5;   // group shift field
  localparam int GWID_W    = 3;   // group width field
  localparam int GRP_W     = 7;   // widest group index
  localparam int PAGE_BITS = 12;  // page offset bits

  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_DETACH = 3'd1,
    SM_RSV2   = 3'd2,
    SM_RSV3   = 3'd3,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_HIGH   = 3'd6,
    SM_LOW    = 3'd7
  } srcMode_e;

  typedef enum logic [2:0] {
    WK_DOMAIN   = 3'd0,
    WK_MODE     = 3'd1,
    WK_SETEN    = 3'd2,
    WK_CLREN    = 3'd3,
    WK_SETPEND  = 3'd4,
    WK_HARTBASE = 3'd5
  } wrKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic            modeWr;
    logic            hartWr;
    logic            setEn;
    logic            clrEn;
    logic            setPend;
    logic [ID_W-1:0] wrId;
    logic [ID_W-1:0] wrIdx;
    logic            capture;
    logic [ID_W-1:0] capId;
    logic            deliver;
    logic [ID_W-1:0] dlvId;
  } gwStrobe_t;

endpackage

// File: rtl/irq_msi_gateway_ctrl.sv
module irq_msi_gateway_ctrl
  import irq_msi_gateway_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_HART = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [2:0]           wrKind,
  input  logic [ID_W-1:0]      wrIndex,
  input  logic [ID_W-1:0]      cfgWord,
  input  logic [NUM_SRC-1:0]   eligible,
  input  logic                 msiReady,
  output logic                 msiValid,
  output logic [ID_W-1:0]      msiId,
  output logic                 domIe,
  output logic                 domMsi,
  output logic [SHIFT_W-1:0]   groupShift,
  output logic [GWID_W-1:0]    groupWidth,
  output gwStrobe_t            stb
);

  localparam logic [ID_W-1:0] SRC_CNT  = ID_W'(NUM_SRC);
  localparam logic [ID_W-1:0] HART_CNT = ID_W'(NUM_HART);

  logic            idValid;
  logic            pickFound;
  logic [ID_W-1:0] pickId;
  logic            busyQ;
  logic [ID_W-1:0] curIdQ;
  logic            gateOpen;

  assign idValid = (cfgWord != '0) && (cfgWord <= SRC_CNT);

  // Write decode
  always_comb begin
    stb         = '0;
    stb.wrId    = cfgWord;
    stb.wrIdx   = wrIndex;
    stb.modeWr  = wrEn && (wrKind == WK_MODE) && (wrIndex < SRC_CNT);
    stb.hartWr  = wrEn && (wrKind == WK_HARTBASE) && (wrIndex < HART_CNT);
    stb.setEn   = wrEn && (wrKind == WK_SETEN) && idValid;
    stb.clrEn   = wrEn && (wrKind == WK_CLREN) && idValid;
    stb.setPend = wrEn && (wrKind == WK_SETPEND) && idValid;
    stb.capture = !busyQ && pickFound && gateOpen;
    stb.capId   = pickId;
    stb.deliver = busyQ && msiReady;
    stb.dlvId   = curIdQ;
  end

  // Domain configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      domIe      <= 1'b0;
      domMsi     <= 1'b0;
      groupShift <= '0;
      groupWidth <= '0;
    end else if (wrEn && wrKind == WK_DOMAIN) begin
      domIe      <= cfgWord[0];
      domMsi     <= cfgWord[1];
      groupShift <= cfgWord[2 +: SHIFT_W];
      groupWidth <= cfgWord[2 + SHIFT_W +: GWID_W];
    end
  end

  assign gateOpen = domIe && domMsi;

  // Lowest identity wins: scan downward, last hit sticks
  always_comb begin
    pickFound = 1'b0;
    pickId    = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        pickFound = 1'b1;
        pickId    = ID_W'(i + 1);
      end
    end
  end

  // Single outstanding message
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      curIdQ <= '0;
    end else if (stb.capture) begin
      busyQ  <= 1'b1;
      curIdQ <= pickId;
    end else if (busyQ && msiReady) begin
      busyQ  <= 1'b0;
    end
  end

  assign msiValid = busyQ;
  assign msiId    = curIdQ;

endmodule

// File: rtl/irq_msi_gateway_datapath.sv
module irq_msi_gateway_datapath
  import irq_msi_gateway_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_HART = 4,
  parameter int DATA_W   = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  gwStrobe_t                   stb,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [NUM_SRC-1:0]          srcIn,
  input  logic [SHIFT_W-1:0]          groupShift,
  input  logic [GWID_W-1:0]           groupWidth,
  output logic [NUM_SRC-1:0]          eligible,
  output logic [DATA_W+PAGE_BITS-1:0] msiAddr,
  output logic [GRP_W-1:0]            msiGroup
);

  localparam int HART_W = (NUM_HART > 1) ? $clog2(NUM_HART) : 1;

  srcMode_e          modeQ   [NUM_SRC];
  logic [HART_W-1:0] hartQ   [NUM_SRC];
  logic [DATA_W-1:0] basePpn [NUM_HART];
  logic [NUM_SRC-1:0] enQ, pendQ, prevQ, pendNext;

  // Per-source trigger logic
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    localparam logic [ID_W-1:0] MY_ID = ID_W'(g + 1);
    logic rise, fall, swSet, sent, active, nxt;

    assign rise   = srcIn[g] & ~prevQ[g];
    assign fall   = ~srcIn[g] & prevQ[g];
    assign swSet  = stb.setPend && (stb.wrId == MY_ID);
    assign sent   = stb.deliver && (stb.dlvId == MY_ID);

    always_comb begin
      active = 1'b1;
      case (modeQ[g])
        SM_DETACH: nxt = swSet | (pendQ[g] & ~sent);
        SM_RISE:   nxt = rise | swSet | (pendQ[g] & ~sent);
        SM_FALL:   nxt = fall | swSet | (pendQ[g] & ~sent);
        SM_HIGH:   nxt = enQ[g] & srcIn[g];
        SM_LOW:    nxt = enQ[g] & ~srcIn[g];
        default: begin
          nxt    = 1'b0;
          active = 1'b0;
        end
      endcase
    end

    assign pendNext[g] = nxt;
    assign eligible[g] = pendQ[g] & enQ[g] & active;
  end

  // Source and hart state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= '0;
      pendQ <= '0;
      prevQ <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        modeQ[i] <= SM_OFF;
        hartQ[i] <= '0;
      end
      for (int h = 0; h < NUM_HART; h++) basePpn[h] <= '0;
    end else begin
      prevQ <= srcIn;
      pendQ <= pendNext;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (stb.modeWr && stb.wrIdx == ID_W'(i)) begin
          modeQ[i] <= srcMode_e'(wrData[2:0]);
          hartQ[i] <= wrData[8 +: HART_W];
        end
        if (stb.setEn && stb.wrId == ID_W'(i + 1))      enQ[i] <= 1'b1;
        else if (stb.clrEn && stb.wrId == ID_W'(i + 1)) enQ[i] <= 1'b0;
      end
      for (int h = 0; h < NUM_HART; h++) begin
        if (stb.hartWr && stb.wrIdx == ID_W'(h)) basePpn[h] <= wrData;
      end
    end
  end

  // Payload selection for the captured identity
  logic [HART_W-1:0]  selHart;
  logic [DATA_W-1:0]  selPpn;
  logic [SHIFT_W:0]   shAmt;
  logic [DATA_W-1:0]  shifted;
  logic [GRP_W-1:0]   grpCalc;
  logic [DATA_W-1:0]  ppnQ;
  logic [GRP_W-1:0]   grpQ;

  always_comb begin
    selHart = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (stb.capId == ID_W'(i + 1)) selHart = hartQ[i];
    selPpn = '0;
    for (int h = 0; h < NUM_HART; h++)
      if (HART_W'(h) == selHart) selPpn = basePpn[h];
  end

  assign shAmt   = {1'b0, groupShift} + (SHIFT_W + 1)'(PAGE_BITS);
  assign shifted = selPpn >> shAmt;
  assign grpCalc = shifted[GRP_W-1:0] & ~({GRP_W{1'b1}} << groupWidth);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ppnQ <= '0;
      grpQ <= '0;
    end else if (stb.capture) begin
      ppnQ <= selPpn;
      grpQ <= grpCalc;
    end
  end

  assign msiAddr  = {ppnQ, {PAGE_BITS{1'b0}}};
  assign msiGroup = grpQ;

endmodule

// File: rtl/irq_msi_gateway.sv
module irq_msi_gateway
  import irq_msi_gateway_pkg::*;
#(
  parameter int  NUM_SRC  = 8,
  parameter int  NUM_HART = 4,
  parameter int  DATA_W   = 32,
  localparam int ADDR_W   = DATA_W + 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrKind,
  input  logic [9:0]         wrIndex,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               msiReady,
  output logic               msiValid,
  output logic [ADDR_W-1:0]  msiAddr,
  output logic [9:0]         msiData,
  output logic [6:0]         msiGroup
);

  gwStrobe_t            stb;
  logic [NUM_SRC-1:0]   eligible;
  logic                 domIe;
  logic                 domMsi;
  logic [SHIFT_W-1:0]   groupShift;
  logic [GWID_W-1:0]    groupWidth;

  irq_msi_gateway_ctrl #(
    .NUM_SRC (NUM_SRC),
    .NUM_HART(NUM_HART)
  ) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrKind    (wrKind),
    .wrIndex   (wrIndex),
    .cfgWord   (wrData[ID_W-1:0]),
    .eligible  (eligible),
    .msiReady  (msiReady),
    .msiValid  (msiValid),
    .msiId     (msiData),
    .domIe     (domIe),
    .domMsi    (domMsi),
    .groupShift(groupShift),
    .groupWidth(groupWidth),
    .stb       (stb)
  );

  irq_msi_gateway_datapath #(
    .NUM_SRC (NUM_SRC),
    .NUM_HART(NUM_HART),
    .DATA_W  (DATA_W)
  ) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .srcIn     (srcIn),
    .groupShift(groupShift),
    .groupWidth(groupWidth),
    .eligible  (eligible),
    .msiAddr   (msiAddr),
    .msiGroup  (msiGroup)
  );

endmodule

// File: rtl/irq_msi_gateway_chk.sv
module irq_msi_gateway_chk #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 44
) (
  input logic              clk,
  input logic              rstN,
  input logic              msiValid,
  input logic              msiReady,
  input logic [ADDR_W-1:0] msiAddr,
  input logic [9:0]        msiData,
  input logic              domIe,
  input logic              domMsi
);

  // R8: payload held while stalled
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    msiValid && !msiReady |=> msiValid && $stable(msiData) && $stable(msiAddr));

  // R8: only one message outstanding, gap after handshake
  assert_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    msiValid && msiReady |=> !msiValid);

  // R2: carried identity is a legal one
  assert_id_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    msiValid |-> (msiData != 10'd0) && (msiData <= 10'(NUM_SRC)));

  // R7: a message starts only while the domain gate was open
  assert_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msiValid) |-> $past(domIe && domMsi));

  // R9: address is page aligned
  assert_page_R9: assert property (@(posedge clk) disable iff (!rstN)
    msiValid |-> msiAddr[11:0] == 12'd0);

endmodule

bind irq_msi_gateway irq_msi_gateway_chk #(
  .NUM_SRC(NUM_SRC),
  .ADDR_W (ADDR_W)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .msiValid(msiValid),
  .msiReady(msiReady),
  .msiAddr (msiAddr),
  .msiData (msiData),
  .domIe   (domIe),
  .domMsi  (domMsi)
);

// File: tb/irq_msi_gateway_test.sv
`timescale 1ns/1ps
module irq_msi_gateway_test;

  localparam int N = 8;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrKind = '0;
  logic [9:0]  wrIndex = '0;
  logic [31:0] wrData = '0;
  logic [N-1:0] srcIn = '0;
  logic        msiReady = 1'b0;
  logic        msiValid;
  logic [43:0] msiAddr;
  logic [9:0]  msiData;
  logic [6:0]  msiGroup;

  irq_msi_gateway #(.NUM_SRC(N), .NUM_HART(H), .DATA_W(32)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .wrIndex(wrIndex),
    .wrData(wrData), .srcIn(srcIn), .msiReady(msiReady), .msiValid(msiValid),
    .msiAddr(msiAddr), .msiData(msiData), .msiGroup(msiGroup)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  int          gotN;
  int          gotId  [64];
  logic [43:0] gotAddr[64];
  logic [6:0]  gotGrp [64];

  logic [31:0] hartPpn[H];
  int          srcHart[N+1];
  int          gShift = 3;
  int          gWidth = 2;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int idx, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrKind = 3'(kind); wrIndex = 10'(idx); wrData = 32'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setMode(input int id, input int mode, input int hart);
    srcHart[id] = hart;
    wr(1, id - 1, (hart << 8) | mode);
  endtask

  task automatic dom(input int ie, input int msi);
    wr(0, 0, ie | (msi << 1) | (gShift << 2) | (gWidth << 7));
  endtask

  function automatic int expGrp(input logic [31:0] ppn, input int sh, input int w);
    longint v;
    v = longint'(ppn) >> (sh + 12);
    return int'(v & ((64'd1 << w) - 1));
  endfunction

  // Collect messages for a number of cycles with a given ready percentage
  task automatic drain(input int cyc, input int readyPct);
    bit          holding = 0;
    logic [43:0] hAddr = '0;
    logic [9:0]  hData = '0;
    gotN = 0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (holding)
        check(msiValid && msiAddr == hAddr && msiData == hData, "R8",
              "payload held under stall", longint'(msiData), longint'(hData));
      msiReady = (int'($urandom % 100) < readyPct);
      if (msiValid && msiReady && gotN < 64) begin
        gotId[gotN]   = int'(msiData);
        gotAddr[gotN] = msiAddr;
        gotGrp[gotN]  = msiGroup;
        gotN++;
      end
      holding = msiValid && !msiReady;
      hAddr = msiAddr;
      hData = msiData;
    end
    @(negedge clk);
    msiReady = 1'b0;
  endtask

  task automatic pulse(input int id);
    @(negedge clk); srcIn[id-1] = 1'b1;
    @(negedge clk); srcIn[id-1] = 1'b0;
  endtask

  initial begin
    int mask;
    int exp;
    int pos;
    bit allSame;
    void'($urandom(32'd2024));
    for (int s = 0; s <= N; s++) srcHart[s] = 0;

    repeat (5) @(negedge clk);
    check(msiValid == 1'b0, "R1", "valid low in reset", msiValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(msiValid == 1'b0, "R1", "valid low after reset", msiValid, 0);

    for (int h = 0; h < H; h++) begin
      hartPpn[h] = $urandom;
      wr(5, h, int'(hartPpn[h]));
    end
    dom(1, 1);

    // R1: default inactive sources stay silent
    for (int s = 1; s <= N; s++) wr(2, 0, s);
    srcIn = '1; repeat (3) @(negedge clk); srcIn = '0;
    drain(12, 100);
    check(gotN == 0, "R1", "reset-state sources silent", gotN, 0);
    for (int s = 1; s <= N; s++) wr(3, 0, s);

    // R2/R6: detached source, identity 0 ignored
    setMode(1, 1, 1);
    wr(4, 0, 1);
    drain(8, 100);
    check(gotN == 0, "R2", "disabled pending source silent", gotN, 0);
    wr(2, 0, 0);
    drain(8, 100);
    check(gotN == 0, "R2", "enable of identity 0 ignored", gotN, 0);
    wr(2, 0, 1);
    drain(8, 100);
    check(gotN == 1 && gotId[0] == 1, "R2", "enable by identity", gotN, 1);
    check(gotAddr[0] == {hartPpn[1], 12'h000}, "R9", "address of hart 1",
          longint'(gotAddr[0]), longint'({hartPpn[1], 12'h000}));
    check(int'(gotGrp[0]) == expGrp(hartPpn[1], gShift, gWidth), "R9", "group index",
          gotGrp[0], expGrp(hartPpn[1], gShift, gWidth));
    pulse(1); pulse(1); srcIn[0] = 1'b1;
    drain(8, 100);
    srcIn[0] = 1'b0;
    check(gotN == 0, "R6", "detached wire ignored", gotN, 0);
    wr(4, 0, 1);
    drain(8, 100);
    check(gotN == 1 && gotId[0] == 1, "R6", "detached set-pending", gotN, 1);

    // R2: disable by identity, identity 0 disable ignored
    setMode(2, 1, 0);
    wr(2, 0, 2);
    wr(3, 0, 2);
    wr(4, 0, 2);
    drain(8, 100);
    check(gotN == 0, "R2", "disable by identity", gotN, 0);
    wr(2, 0, 2);
    wr(3, 0, 0);
    drain(8, 100);
    check(gotN == 1 && gotId[0] == 2, "R2", "disable of identity 0 ignored", gotId[0], 2);

    // R3: reserved mode acts inactive
    setMode(3, 2, 0);
    wr(2, 0, 3);
    wr(4, 0, 3);
    pulse(3);
    srcIn[2] = 1'b1;
    drain(8, 100);
    check(gotN == 0, "R3", "reserved mode 2 silent", gotN, 0);
    srcIn[2] = 1'b0;
    setMode(3, 3, 0);
    wr(4, 0, 3);
    pulse(3);
    drain(8, 100);
    check(gotN == 0, "R3", "reserved mode 3 silent", gotN, 0);
    setMode(3, 1, 0);
    drain(8, 100);
    check(gotN == 0, "R3", "pending dropped in reserved mode", gotN, 0);

    // R10: pending dropped through mode 0
    setMode(4, 4, 2);
    wr(2, 0, 4);
    dom(0, 1);
    pulse(4);
    drain(6, 100);
    check(gotN == 0, "R7", "blocked while domain disabled", gotN, 0);
    setMode(4, 0, 2);
    setMode(4, 4, 2);
    dom(1, 1);
    drain(8, 100);
    check(gotN == 0, "R10", "inactive clears pending", gotN, 0);

    // R7: gating by enable and delivery mode
    dom(0, 1);
    setMode(5, 4, 3);
    wr(2, 0, 5);
    pulse(5);
    drain(6, 100);
    check(gotN == 0, "R7", "global enable off", gotN, 0);
    dom(1, 0);
    drain(6, 100);
    check(gotN == 0, "R7", "delivery mode off", gotN, 0);
    dom(1, 1);
    drain(8, 100);
    check(gotN == 1 && gotId[0] == 5, "R7", "pending kept then sent", gotN, 1);

    // R4: edges
    srcIn[4] = 1'b1;
    drain(8, 100);
    check(gotN == 1 && gotId[0] == 5, "R4", "rising edge once", gotN, 1);
    drain(10, 100);
    check(gotN == 0, "R4", "held high no repeat", gotN, 0);
    srcIn[4] = 1'b0;
    drain(6, 100);
    check(gotN == 0, "R4", "falling edge ignored in rising mode", gotN, 0);
    setMode(6, 5, 0);
    wr(2, 0, 6);
    srcIn[5] = 1'b1;
    drain(8, 100);
    check(gotN == 0, "R4", "rising ignored in falling mode", gotN, 0);
    srcIn[5] = 1'b0;
    drain(8, 100);
    check(gotN == 1 && gotId[0] == 6, "R4", "falling edge once", gotN, 1);

    // R5: level high
    setMode(7, 6, 1);
    wr(2, 0, 7);
    srcIn[6] = 1'b1;
    drain(20, 100);
    allSame = 1;
    for (int k = 0; k < gotN; k++) if (gotId[k] != 7) allSame = 0;
    check(gotN >= 5 && allSame, "R5", "level high repeats", gotN, 5);
    srcIn[6] = 1'b0;
    drain(4, 100);
    drain(10, 100);
    check(gotN == 0, "R5", "level high deasserted quiet", gotN, 0);
    wr(3, 0, 7);
    srcIn[6] = 1'b1;
    drain(4, 100);
    drain(10, 100);
    check(gotN == 0, "R5", "disabled level quiet", gotN, 0);
    srcIn[6] = 1'b0;

    // R5: level low
    srcIn[7] = 1'b1;
    setMode(8, 7, 2);
    wr(2, 0, 8);
    drain(10, 100);
    check(gotN == 0, "R5", "level low idle while high", gotN, 0);
    srcIn[7] = 1'b0;
    drain(20, 100);
    allSame = 1;
    for (int k = 0; k < gotN; k++) if (gotId[k] != 8) allSame = 0;
    check(gotN >= 5 && allSame, "R5", "level low repeats", gotN, 5);
    srcIn[7] = 1'b1;
    drain(4, 100);
    drain(10, 100);
    check(gotN == 0, "R5", "level low released quiet", gotN, 0);

    // R8/R9: random pending sets, released against stalling ready
    for (int it = 0; it < 20; it++) begin
      gShift = int'($urandom % 9);
      gWidth = int'($urandom % 8);
      dom(0, 1);
      for (int h = 0; h < H; h++) begin
        hartPpn[h] = $urandom;
        wr(5, h, int'(hartPpn[h]));
      end
      for (int s = 1; s <= N; s++) begin
        setMode(s, 1, int'($urandom % H));
        wr(2, 0, s);
      end
      mask = int'($urandom % 255) + 1;
      for (int s = 1; s <= N; s++) if (mask[s-1]) wr(4, 0, s);
      dom(1, 1);
      drain(120, 40);
      exp = $countones(mask);
      check(gotN == exp, "R8", "random set count", gotN, exp);
      pos = 0;
      for (int s = 1; s <= N; s++) begin
        if (mask[s-1] && pos < gotN) begin
          check(gotId[pos] == s, "R8", "ascending order", gotId[pos], s);
          check(gotAddr[pos] == {hartPpn[srcHart[s]], 12'h000}, "R9", "random address",
                longint'(gotAddr[pos]), longint'({hartPpn[srcHart[s]], 12'h000}));
          check(int'(gotGrp[pos]) == expGrp(hartPpn[srcHart[s]], gShift, gWidth), "R9",
                "random group", gotGrp[pos], expGrp(hartPpn[srcHart[s]], gShift, gWidth));
          pos++;
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule